// File: doc/BRIEF.md
# Trap Level and Vector Selector

This block decides how each incoming trap is taken. It keeps the current trap level. On each trap request it looks at that level, at the RED-state enable bit of the current hyperprivileged-state register, at the current privilege level and at the trap type. From these it picks one of four outcomes: privileged trap, hyperprivileged trap, RED-state entry or error-state entry. It registers the chosen outcome together with the vector trap type and the new trap level. When the level rises, it pulses a save strobe so that the surrounding pipeline pushes the current state onto the trap stack entry named by the new level.

The block also serves the trap-return path. A return request carries the saved state word and the saved hyperprivileged state. The block loads the ASI, CCR and GL fields and the hyperprivileged state from those values into output registers, then lowers the trap level by one. The vector base registers, the trap stack storage and the decode that raises the trap sit outside this block.

Top module: `trap_vector_sel`

## Requirements
- R1: After synchronous reset, the trap level is 0, the mode is privileged (code 0), the vector is 0, the save strobe is low, the save index is 0, and the ASI, CCR, GL and restored hyperprivileged state outputs are all 0.
- R2: A trap taken while the RED enable input is 1, or while the trap level equals MAX_TL-1, selects RED mode (code 2) with vector 5. This check comes before every other one.
- R3: A trap taken at trap level MAX_TL with the RED enable at 0 selects error mode (code 3) and passes the trap type through as the vector. The trap level stays the same and no save strobe is raised.
- R4: A trap taken by privileged code (privilege code 1) at a trap level above MAX_PTL, when R2 and R3 do not apply, selects hyperprivileged mode (code 1) with the guest-watchdog vector 2, whatever the trap type.
- R5: When none of R2 to R4 applies, a trap selects hyperprivileged mode with the trap type as vector if the privilege code is 2 or 3, or if the privilege code is 1 and the trap type is 384 or more.
- R6: Every other trap, including any trap from user code (privilege code 0), selects privileged mode with the trap type as vector.
- R7: Any trap except an error-state trap raises the trap level by one, saturating at MAX_TL. Each increase raises the save strobe for exactly one cycle, with the save index equal to the new level. The mode, vector and level outputs appear in the cycle after the request edge.
- R8: A return request at a trap level above 0 loads ASI from saved bits 31:24, CCR from bits 39:32, GL from bits 42:40 and the hyperprivileged state from its saved copy, and lowers the trap level by one.
- R9: A return request at trap level 0 has no effect: the level stays 0 and the restored outputs keep their values.
- R10: When a trap request and a return request arrive in the same cycle, the trap is taken and the return is ignored.
- R11: Without a trap request, the mode and vector outputs hold their values and the save strobe stays low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | TT_W | Incoming trap type |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 privileged, 2 or 3 hyperprivileged |
| hstate_red | input | 1 | RED enable bit of the current hyperprivileged state |
| ret_req | input | 1 | Trap-return request |
| saved_state | input | 19 (bits 42:24) | Saved state word, GL at 42:40, CCR at 39:32, ASI at 31:24 |
| saved_hstate | input | HS_W | Saved hyperprivileged state |
| mode_out | output | 2 | Selected mode: 0 privileged, 1 hyperprivileged, 2 RED, 3 error |
| vec_out | output | TT_W | Vector trap type |
| tl_out | output | TL_W | Current trap level |
| save_stb | output | 1 | One-cycle request to push state onto the trap stack |
| save_idx | output | TL_W | Trap stack entry for the push |
| asi_out | output | 8 | Restored ASI |
| ccr_out | output | 8 | Restored CCR |
| gl_out | output | 3 | Restored GL |
| hstate_out | output | HS_W | Restored hyperprivileged state |

## Verification
A trap request and a return request can arrive in the same cycle, and both want to change the trap level. The bench raises the trap level to 1 and then drives a privileged trap and a return with distinctive saved fields on the same edge. It counts the outcome as correct only if the level rises to 2, the save strobe fires with index 2 and the restored ASI, CCR, GL and hyperprivileged outputs keep their earlier values. A second case makes a return alone at level 0 and checks that nothing moves, so a return that is blocked differs visibly from one that is taken.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;
  typedef enum logic [1:0] {
    TMODE_PRIV  = 2'd0,
    TMODE_HYPER = 2'd1,
    TMODE_RED   = 2'd2,
    TMODE_ERROR = 2'd3
  } tmode_e;

  localparam logic [1:0] PL_USER = 2'd0;
  localparam logic [1:0] PL_PRIV = 2'd1;
endpackage

// File: rtl/trap_route_decide.sv
module trap_route_decide
  import trap_sel_pkg::*;
#(
  parameter int TL_W       = 3,
  parameter int TT_W       = 9,
  parameter int MAX_TL     = 6,
  parameter int MAX_PTL    = 2,
  parameter int HYP_TT_MIN = 384,
  parameter int VEC_RED    = 5,
  parameter int VEC_WDOG   = 2
) (
  input  logic [TL_W-1:0] tl_i,
  input  logic            red_i,
  input  logic [1:0]      priv_i,
  input  logic [TT_W-1:0] tt_i,
  output tmode_e          mode_o,
  output logic [TT_W-1:0] vec_o,
  output logic            adv_o
);
  localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_EDGE = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_PTOP = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYP_TT_MIN);

  logic is_priv, is_hyper;
  assign is_priv  = (priv_i == PL_PRIV);
  assign is_hyper = priv_i[1];

  always_comb begin
    mode_o = TMODE_PRIV;
    vec_o  = tt_i;
    adv_o  = 1'b1;
    if (red_i || tl_i == TL_EDGE) begin
      mode_o = TMODE_RED;
      vec_o  = TT_W'(VEC_RED);
    end else if (tl_i == TL_TOP) begin
      mode_o = TMODE_ERROR;
      adv_o  = 1'b0;
    end else if (tl_i > TL_PTOP && is_priv) begin
      mode_o = TMODE_HYPER;
      vec_o  = TT_W'(VEC_WDOG);
    end else if (is_hyper || (is_priv && tt_i >= TT_HMIN)) begin
      mode_o = TMODE_HYPER;
    end
  end

  always_comb begin
    assert_err_no_adv_R3: assert (mode_o != TMODE_ERROR || !red_i);
  end
endmodule

// File: rtl/trap_level_ctr.sv
module trap_level_ctr #(
  parameter int TL_W   = 3,
  parameter int MAX_TL = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic            adv_i,
  input  logic            ret_i,
  output logic            ret_fire_o,
  output logic [TL_W-1:0] tl_o,
  output logic            stb_o,
  output logic [TL_W-1:0] idx_o
);
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

  logic [TL_W-1:0] tl_q;
  logic            inc;

  assign inc        = take_i && adv_i && (tl_q != TL_TOP);
  assign ret_fire_o = ret_i && !take_i && (tl_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q  <= '0;
      stb_o <= 1'b0;
      idx_o <= '0;
    end else begin
      stb_o <= inc;
      if (inc) begin
        tl_q  <= tl_q + 1'b1;
        idx_o <= tl_q + 1'b1;
      end else if (ret_fire_o) begin
        tl_q  <= tl_q - 1'b1;
      end
    end
  end

  assign tl_o = tl_q;

  assert_tl_bound_R7: assert property (@(posedge clk) disable iff (rst)
    tl_q <= TL_TOP);
  assert_stb_step_R7: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> (tl_q == $past(tl_q) + 1'b1));
  assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (stb_o && !take_i) |=> !stb_o);
endmodule

// File: rtl/trap_return_restore.sv
module trap_return_restore #(
  parameter int HS_W    = 12,
  parameter int ASI_LSB = 24,
  parameter int CCR_LSB = 32,
  parameter int GL_LSB  = 40,
  parameter int GL_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fire_i,
  input  logic [GL_LSB+GL_W-1:ASI_LSB] state_i,
  input  logic [HS_W-1:0]             hs_i,
  output logic [7:0]                  asi_o,
  output logic [7:0]                  ccr_o,
  output logic [GL_W-1:0]             gl_o,
  output logic [HS_W-1:0]             hs_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      asi_o <= '0;
      ccr_o <= '0;
      gl_o  <= '0;
      hs_o  <= '0;
    end else if (fire_i) begin
      asi_o <= state_i[ASI_LSB +: 8];
      ccr_o <= state_i[CCR_LSB +: 8];
      gl_o  <= state_i[GL_LSB +: GL_W];
      hs_o  <= hs_i;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> ($stable(asi_o) && $stable(ccr_o) && $stable(gl_o) && $stable(hs_o)));
endmodule

// File: rtl/trap_vector_sel.sv
module trap_vector_sel
  import trap_sel_pkg::*;
#(
  parameter int TL_W       = 3,
  parameter int TT_W       = 9,
  parameter int HS_W       = 12,
  parameter int MAX_TL     = 6,
  parameter int MAX_PTL    = 2,
  parameter int HYP_TT_MIN = 384,
  parameter int VEC_RED    = 5,
  parameter int VEC_WDOG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_req,
  input  logic [TT_W-1:0]  trap_type,
  input  logic [1:0]       priv_lvl,
  input  logic             hstate_red,
  input  logic             ret_req,
  input  logic [42:24]     saved_state,
  input  logic [HS_W-1:0]  saved_hstate,
  output logic [1:0]       mode_out,
  output logic [TT_W-1:0]  vec_out,
  output logic [TL_W-1:0]  tl_out,
  output logic             save_stb,
  output logic [TL_W-1:0]  save_idx,
  output logic [7:0]       asi_out,
  output logic [7:0]       ccr_out,
  output logic [2:0]       gl_out,
  output logic [HS_W-1:0]  hstate_out
);
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

  tmode_e            dec_mode;
  logic [TT_W-1:0]   dec_vec;
  logic              dec_adv;
  logic              ret_fire;
  logic [TL_W-1:0]   tl_cur;
  tmode_e            mode_q;
  logic [TT_W-1:0]   vec_q;

  trap_route_decide #(
    .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL),
    .HYP_TT_MIN(HYP_TT_MIN), .VEC_RED(VEC_RED), .VEC_WDOG(VEC_WDOG)
  ) u_decide (
    .tl_i(tl_cur), .red_i(hstate_red), .priv_i(priv_lvl), .tt_i(trap_type),
    .mode_o(dec_mode), .vec_o(dec_vec), .adv_o(dec_adv)
  );

  trap_level_ctr #(.TL_W(TL_W), .MAX_TL(MAX_TL)) u_level (
    .clk(clk), .rst(rst), .take_i(trap_req), .adv_i(dec_adv), .ret_i(ret_req),
    .ret_fire_o(ret_fire), .tl_o(tl_cur), .stb_o(save_stb), .idx_o(save_idx)
  );

  trap_return_restore #(.HS_W(HS_W)) u_restore (
    .clk(clk), .rst(rst), .fire_i(ret_fire), .state_i(saved_state),
    .hs_i(saved_hstate), .asi_o(asi_out), .ccr_o(ccr_out), .gl_o(gl_out),
    .hs_o(hstate_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TMODE_PRIV;
      vec_q  <= '0;
    end else if (trap_req) begin
      mode_q <= dec_mode;
      vec_q  <= dec_vec;
    end
  end

  assign mode_out = mode_q;
  assign vec_out  = vec_q;
  assign tl_out   = tl_cur;

  assert_red_first_R2: assert property (@(posedge clk) disable iff (rst)
    (trap_req && hstate_red) |=> (mode_q == TMODE_RED && vec_q == TT_W'(VEC_RED)));
  assert_error_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !hstate_red && tl_cur == TL_TOP) |=>
      (mode_q == TMODE_ERROR && tl_cur == TL_TOP && !save_stb));
  assert_ret_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !trap_req && tl_cur == '0) |=> (tl_cur == '0 && $stable(asi_out)));
  assert_trap_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (trap_req && ret_req) |=> ($stable(asi_out) && $stable(hstate_out)));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> ($stable(mode_q) && $stable(vec_q) && !save_stb));
endmodule

// File: tb/sim_trap_vector_sel.sv
module sim_trap_vector_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trap_req = 1'b0;
  logic [8:0]  trap_type = '0;
  logic [1:0]  priv_lvl = '0;
  logic        hstate_red = 1'b0;
  logic        ret_req = 1'b0;
  logic [42:24] saved_state = '0;
  logic [11:0] saved_hstate = '0;
  logic [1:0]  mode_out;
  logic [8:0]  vec_out;
  logic [2:0]  tl_out;
  logic        save_stb;
  logic [2:0]  save_idx;
  logic [7:0]  asi_out, ccr_out;
  logic [2:0]  gl_out;
  logic [11:0] hstate_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_vector_sel u0 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
    .priv_lvl(priv_lvl), .hstate_red(hstate_red), .ret_req(ret_req),
    .saved_state(saved_state), .saved_hstate(saved_hstate),
    .mode_out(mode_out), .vec_out(vec_out), .tl_out(tl_out),
    .save_stb(save_stb), .save_idx(save_idx), .asi_out(asi_out),
    .ccr_out(ccr_out), .gl_out(gl_out), .hstate_out(hstate_out)
  );

  // {start_tl[3], priv[2], red[1], tt[9], exp_mode[2], exp_vec[9], exp_tl[3], exp_stb[1]}
  localparam int NV = 14;
  localparam logic [29:0] VECS [NV] = '{
    {3'd0, 2'd0, 1'b0, 9'd20,  2'd0, 9'd20,  3'd1, 1'b1}, // R6 user
    {3'd0, 2'd1, 1'b0, 9'd20,  2'd0, 9'd20,  3'd1, 1'b1}, // R6 priv
    {3'd0, 2'd1, 1'b0, 9'd384, 2'd1, 9'd384, 3'd1, 1'b1}, // R5 threshold
    {3'd0, 2'd1, 1'b0, 9'd383, 2'd0, 9'd383, 3'd1, 1'b1}, // R6 below threshold
    {3'd1, 2'd2, 1'b0, 9'd48,  2'd1, 9'd48,  3'd2, 1'b1}, // R5 hyper
    {3'd2, 2'd1, 1'b0, 9'd20,  2'd0, 9'd20,  3'd3, 1'b1}, // R4 boundary
    {3'd3, 2'd1, 1'b0, 9'd20,  2'd1, 9'd2,   3'd4, 1'b1}, // R4 watchdog
    {3'd3, 2'd0, 1'b0, 9'd20,  2'd0, 9'd20,  3'd4, 1'b1}, // R6 user high tl
    {3'd3, 2'd3, 1'b0, 9'd20,  2'd1, 9'd20,  3'd4, 1'b1}, // R5 code 3
    {3'd4, 2'd1, 1'b0, 9'd500, 2'd1, 9'd2,   3'd5, 1'b1}, // R4 over threshold
    {3'd5, 2'd1, 1'b0, 9'd20,  2'd2, 9'd5,   3'd6, 1'b1}, // R2 tl edge
    {3'd1, 2'd1, 1'b1, 9'd20,  2'd2, 9'd5,   3'd2, 1'b1}, // R2 enable bit
    {3'd6, 2'd1, 1'b0, 9'd20,  2'd3, 9'd20,  3'd6, 1'b0}, // R3 error
    {3'd6, 2'd2, 1'b1, 9'd20,  2'd2, 9'd5,   3'd6, 1'b0}  // R2 and R7 saturate
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; trap_req = 1'b0; ret_req = 1'b0; hstate_red = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_trap(input logic [1:0] pl, input logic red, input logic [8:0] tt);
    priv_lvl = pl; hstate_red = red; trap_type = tt; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0; hstate_red = 1'b0;
  endtask

  task automatic climb(input int k);
    do_reset();
    for (int j = 0; j < k; j++) pulse_trap(2'd0, 1'b0, 9'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(tl_out == 0 && mode_out == 0 && vec_out == 0 && !save_stb && save_idx == 0,
          "R1 reset core", {tl_out, mode_out, vec_out, save_stb}, 0);
    check(asi_out == 0 && ccr_out == 0 && gl_out == 0 && hstate_out == 0,
          "R1 reset restored", {asi_out, ccr_out, hstate_out[3:0]}, 0);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [29:0] e;
      e = VECS[i];
      climb(int'(e[29:27]));
      pulse_trap(e[26:25], e[24], e[23:15]);
      check(mode_out == e[14:13], $sformatf("R2-R6 mode row %0d", i), mode_out, e[14:13]);
      check(vec_out == e[12:4], $sformatf("R2-R6 vector row %0d", i), vec_out, e[12:4]);
      check(tl_out == e[3:1], $sformatf("R7 level row %0d", i), tl_out, e[3:1]);
      check(save_stb == e[0] && (!e[0] || save_idx == e[3:1]),
            $sformatf("R7 strobe row %0d", i), {save_stb, save_idx}, {e[0], e[3:1]});
      @(negedge clk);
      check(!save_stb, $sformatf("R7 single pulse row %0d", i), save_stb, 0);
    end

    // R8 return restores fields
    climb(2);
    saved_state = {3'd5, 8'hA5, 8'h3C};
    saved_hstate = 12'h0AB;
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    check(asi_out == 8'h3C && ccr_out == 8'hA5 && gl_out == 3'd5,
          "R8 fields", {gl_out, ccr_out, asi_out}, {3'd5, 8'hA5, 8'h3C});
    check(hstate_out == 12'h0AB && tl_out == 3'd1, "R8 hstate and level",
          {hstate_out, tl_out}, {12'h0AB, 3'd1});

    // R9 return at level zero
    do_reset();
    saved_state = {3'd7, 8'hFF, 8'hEE};
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    check(tl_out == 0 && asi_out == 0 && ccr_out == 0 && gl_out == 0,
          "R9 ignored at zero", {tl_out, asi_out}, 0);

    // R10 trap and return together
    climb(1);
    saved_state = {3'd6, 8'h11, 8'h22};
    saved_hstate = 12'h555;
    ret_req = 1'b1;
    pulse_trap(2'd1, 1'b0, 9'd7);
    ret_req = 1'b0;
    check(tl_out == 3'd2 && save_stb && save_idx == 3'd2 && vec_out == 9'd7,
          "R10 trap taken", {tl_out, save_stb, vec_out}, {3'd2, 1'b1, 9'd7});
    check(asi_out == 0 && hstate_out == 0 && gl_out == 0,
          "R10 return ignored", {asi_out, hstate_out}, 0);

    // R11 hold without request
    priv_lvl = 2'd2; trap_type = 9'd400; hstate_red = 1'b1;
    repeat (3) @(negedge clk);
    check(mode_out == 2'd0 && vec_out == 9'd7 && !save_stb && tl_out == 3'd2,
          "R11 outputs hold", {mode_out, vec_out, save_stb}, {2'd0, 9'd7, 1'b0});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule